// File: doc/BRIEF.md
# Address-Space-Tagged Translation Lookaside Buffer

This block translates virtual addresses to physical addresses for one memory port. It holds a parameterised number of translations (128 by default), and any translation may sit in any slot. Each slot is keyed by a virtual page number together with an 8-bit address space number. Entries from several processes can therefore live side by side, and a context switch needs no flush. A lookup presents the virtual address, the current address space number and the access kind (read or write, user or kernel). In the same cycle, with no register on the path, the block answers hit, miss or protection fault, along with the physical address. On a successful hit it marks the slot as used, and a write hit also marks it dirty.

Refill is done by software through a fill port. A fill whose page and address space number are already present rewrites that slot in place. Any other fill goes to the slot named by a round-robin victim pointer, which then steps forward. Two flush inputs drop every slot, or only the slots of one address space.

Each cycle the maintenance side settles into one named operation, picked by priority. OP_FLUSH_ALL is chosen when the flush-all input is high. OP_FLUSH_ASN is chosen when the flush-by-space input is high and flush-all is not. OP_REFILL is chosen when the fill input is high and no flush is requested. OP_IDLE covers every other cycle. There are four transitions, one into each operation, and they are taken fresh each cycle from the inputs, so no operation outlasts its cycle. Lookups run in parallel with all four operations.

Top module: `asn_tlb`

## Requirements
- R1: After reset no slot is valid, so every lookup reports a miss (miss=1, hit=0, fault=0).
- R2: A permitted lookup that matches reports hit=1 in the same cycle it is presented. The physical address is the 28-bit frame number of the matching slot above the low 13 virtual address bits, which pass through unchanged. The virtual page number is bits 47:13 of the virtual address.
- R3: A slot matches only when both its virtual page number and its address space number equal the lookup's. The same page may be held under different address space numbers, and each lookup gets its own frame.
- R4: The 4-bit permission field of a fill is indexed by {user, write}. Bit 0 is kernel read, bit 1 kernel write, bit 2 user read and bit 3 user write. A matching access whose bit is 0 reports fault=1 and hit=0, and its physical address output is 0.
- R5: A successful hit sets the slot's use bit; a fault does not. The use bit held before the access is reported on lk_used, whenever a slot matches.
- R6: A successful write hit sets the slot's dirty bit. Read hits and faults leave it unchanged. The dirty bit held before the access is reported on lk_dirty, whenever a slot matches.
- R7: A lookup with no matching valid slot reports miss=1, hit=0, fault=0 and a physical address of 0.
- R8: A fill of a page that is not yet present writes the slot at the victim pointer. The pointer starts at 0 after reset, steps by one after each such fill, and wraps from N-1 to 0. So with N slots, fill N+1 replaces the translation of fill 1.
- R9: A fill whose page and address space number match a valid slot rewrites that slot, and the victim pointer stays where it is. No lookup ever matches two slots.
- R10: A fill loads its slot with use=0 and dirty=0.
- R11: Flush-all clears every slot in one cycle.
- R12: Flush-by-space clears only the slots whose address space number equals the given one.
- R13: A fill presented in the same cycle as either flush is dropped, and the victim pointer does not move.
- R14: When a lookup and a fill of the same slot share a cycle, the lookup answers from the old contents. The fill's contents replace the slot, with use=0 and dirty=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 48 | Virtual address |
| lk_asn | input | 8 | Current address space number |
| lk_write | input | 1 | 1 = write access |
| lk_user | input | 1 | 1 = user mode, 0 = kernel mode |
| lk_hit | output | 1 | Permitted match |
| lk_miss | output | 1 | No matching valid slot |
| lk_fault | output | 1 | Match without permission |
| lk_paddr | output | 41 | Physical address (0 unless hit) |
| lk_used | output | 1 | Use bit of the matching slot before this access |
| lk_dirty | output | 1 | Dirty bit of the matching slot before this access |
| fl_valid | input | 1 | Fill request |
| fl_vpn | input | 35 | Fill virtual page number |
| fl_asn | input | 8 | Fill address space number |
| fl_pfn | input | 28 | Fill physical frame number |
| fl_perm | input | 4 | Fill permissions, indexed by {user, write} |
| inv_all | input | 1 | Flush every slot |
| inv_asn_valid | input | 1 | Flush slots of one address space |
| inv_asn | input | 8 | Address space number to flush |

## Verification
The bench makes a write lookup and a fill land on the same slot in the same cycle. It checks that the lookup answers with the old frame, and that the following read shows the new frame with use and dirty both clear. It also puts a fill in the same cycle as flush-all, and another in the same cycle as a flush of a different address space. In both cases the fill must be gone afterwards. The round-robin pointer is judged after a wrap and after an in-place rewrite, by checking which pages still hit and which now miss.

// File: rtl/tlb_pkg.sv
`timescale 1ns/1ps
package tlb_pkg;
    typedef enum logic [1:0] {
        OP_IDLE,
        OP_REFILL,
        OP_FLUSH_ASN,
        OP_FLUSH_ALL
    } maint_op_e;

    localparam int PERM_W = 4;
endpackage

// File: rtl/tlb_match.sv
`timescale 1ns/1ps
module tlb_match #(
    parameter int N  = 128,
    parameter int KW = 43,
    localparam int IDXW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]         vld,
    input  logic [N-1:0][KW-1:0] keys,
    input  logic [KW-1:0]        probe,
    output logic [N-1:0]         hits,
    output logic                 any,
    output logic [IDXW-1:0]      idx
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hits[g] = vld[g] && (keys[g] == probe);
    end

    assign any = |hits;

    // lowest index wins
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) idx = IDXW'(i);
        end
    end
endmodule

// File: rtl/tlb_victim.sv
`timescale 1ns/1ps
module tlb_victim #(
    parameter int N = 128,
    localparam int IDXW = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            adv,
    output logic [IDXW-1:0] ptr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ptr <= '0;
        else if (adv)
            ptr <= (ptr == IDXW'(N - 1)) ? '0 : ptr + 1'b1;
    end

    // R8: pointer holds unless a new-page fill consumes it
    a_r8_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(ptr));
    // R8: wrap from the last slot to slot 0
    a_r8_ptr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && ptr == IDXW'(N - 1)) |=> ptr == '0);
endmodule

// File: rtl/asn_tlb.sv
`timescale 1ns/1ps
module asn_tlb #(
    parameter int N    = 128,
    parameter int VAW  = 48,
    parameter int PAW  = 41,
    parameter int OFFW = 13,
    parameter int ASNW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lk_valid,
    input  logic [VAW-1:0]       lk_vaddr,
    input  logic [ASNW-1:0]      lk_asn,
    input  logic                 lk_write,
    input  logic                 lk_user,
    output logic                 lk_hit,
    output logic                 lk_miss,
    output logic                 lk_fault,
    output logic [PAW-1:0]       lk_paddr,
    output logic                 lk_used,
    output logic                 lk_dirty,
    input  logic                 fl_valid,
    input  logic [VAW-OFFW-1:0]  fl_vpn,
    input  logic [ASNW-1:0]      fl_asn,
    input  logic [PAW-OFFW-1:0]  fl_pfn,
    input  logic [3:0]           fl_perm,
    input  logic                 inv_all,
    input  logic                 inv_asn_valid,
    input  logic [ASNW-1:0]      inv_asn
);
    import tlb_pkg::*;

    localparam int VPNW = VAW - OFFW;
    localparam int PFNW = PAW - OFFW;
    localparam int KW   = VPNW + ASNW;
    localparam int IDXW = (N > 1) ? $clog2(N) : 1;

    // slot storage
    logic [N-1:0]               e_vld;
    logic [N-1:0]               e_use;
    logic [N-1:0]               e_dirty;
    logic [N-1:0][KW-1:0]       e_key;
    logic [N-1:0][PFNW-1:0]     e_pfn;
    logic [N-1:0][PERM_W-1:0]   e_perm;

    // lookup side
    logic [N-1:0]    m_hits;
    logic            m_any;
    logic [IDXW-1:0] m_idx;
    logic            allowed;

    tlb_match #(.N(N), .KW(KW)) u_lk_match (
        .vld   (e_vld),
        .keys  (e_key),
        .probe ({lk_vaddr[VAW-1:OFFW], lk_asn}),
        .hits  (m_hits),
        .any   (m_any),
        .idx   (m_idx)
    );

    assign allowed  = e_perm[m_idx][{lk_user, lk_write}];
    assign lk_hit   = lk_valid && m_any && allowed;
    assign lk_fault = lk_valid && m_any && !allowed;
    assign lk_miss  = lk_valid && !m_any;
    assign lk_paddr = lk_hit ? {e_pfn[m_idx], lk_vaddr[OFFW-1:0]} : '0;
    assign lk_used  = (lk_valid && m_any) ? e_use[m_idx]   : 1'b0;
    assign lk_dirty = (lk_valid && m_any) ? e_dirty[m_idx] : 1'b0;

    // maintenance operation: next-op decode and output decode
    maint_op_e op;
    logic do_flush_all, do_flush_asn, do_refill;

    always_comb begin
        if (inv_all)            op = OP_FLUSH_ALL;
        else if (inv_asn_valid) op = OP_FLUSH_ASN;
        else if (fl_valid)      op = OP_REFILL;
        else                    op = OP_IDLE;
    end

    always_comb begin
        do_flush_all = 1'b0;
        do_flush_asn = 1'b0;
        do_refill    = 1'b0;
        unique case (op)
            OP_IDLE:      ;
            OP_REFILL:    do_refill    = 1'b1;
            OP_FLUSH_ASN: do_flush_asn = 1'b1;
            OP_FLUSH_ALL: do_flush_all = 1'b1;
            default:      ;
        endcase
    end

    // fill side
    logic [N-1:0]    f_hits;
    logic            f_any;
    logic [IDXW-1:0] f_idx;
    logic [IDXW-1:0] vic_ptr;
    logic [IDXW-1:0] fill_idx;

    tlb_match #(.N(N), .KW(KW)) u_fl_match (
        .vld   (e_vld),
        .keys  (e_key),
        .probe ({fl_vpn, fl_asn}),
        .hits  (f_hits),
        .any   (f_any),
        .idx   (f_idx)
    );

    tlb_victim #(.N(N)) u_victim (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (do_refill && !f_any),
        .ptr   (vic_ptr)
    );

    assign fill_idx = f_any ? f_idx : vic_ptr;

    for (genvar g = 0; g < N; g++) begin : g_slot
        logic tgt, upd;
        assign tgt = do_refill && (fill_idx == IDXW'(g));
        assign upd = lk_hit && (m_idx == IDXW'(g)) && !tgt && !do_flush_all;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                e_vld[g]   <= 1'b0;
                e_use[g]   <= 1'b0;
                e_dirty[g] <= 1'b0;
            end else begin
                if (do_flush_all)
                    e_vld[g] <= 1'b0;
                else if (do_flush_asn && e_key[g][ASNW-1:0] == inv_asn)
                    e_vld[g] <= 1'b0;
                else if (tgt)
                    e_vld[g] <= 1'b1;

                if (tgt)
                    e_use[g] <= 1'b0;
                else if (upd)
                    e_use[g] <= 1'b1;

                if (tgt)
                    e_dirty[g] <= 1'b0;
                else if (upd && lk_write)
                    e_dirty[g] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (tgt) begin
                e_key[g]  <= {fl_vpn, fl_asn};
                e_pfn[g]  <= fl_pfn;
                e_perm[g] <= fl_perm;
            end
        end
    end

    // R4: hit and fault never together
    a_r4_hit_fault_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_hit && lk_fault));
    // R7: a miss carries no hit, fault or address
    a_r7_miss_clean: assert property (@(posedge clk) disable iff (!rst_n)
        lk_miss |-> (!lk_hit && !lk_fault && lk_paddr == '0));
    // R9: never two matching slots
    a_r9_unique_match: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(m_hits) <= 1);
    // R6: a write hit leaves the slot dirty
    a_r6_dirty_set: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit && lk_write && !do_flush_all && !(do_refill && fill_idx == m_idx))
        |=> e_dirty[$past(m_idx)]);
    // R11: flush-all empties the buffer
    a_r11_flush_all: assert property (@(posedge clk) disable iff (!rst_n)
        do_flush_all |=> (e_vld == '0));
    // R13: a fill beside a flush does not move the pointer
    a_r13_fill_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_valid && (inv_all || inv_asn_valid)) |=> $stable(vic_ptr));
endmodule

// File: tb/asn_tlb_test.sv
`timescale 1ns/1ps
module asn_tlb_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 0, lk_write = 0, lk_user = 0;
    logic [47:0] lk_vaddr = '0;
    logic [7:0]  lk_asn = '0;
    logic        lk_hit, lk_miss, lk_fault, lk_used, lk_dirty;
    logic [40:0] lk_paddr;
    logic        fl_valid = 0;
    logic [34:0] fl_vpn = '0;
    logic [7:0]  fl_asn = '0;
    logic [27:0] fl_pfn = '0;
    logic [3:0]  fl_perm = '0;
    logic        inv_all = 0, inv_asn_valid = 0;
    logic [7:0]  inv_asn = '0;

    int total = 0;
    int bad = 0;

    // captured lookup outputs
    logic        r_hit, r_miss, r_fault, r_used, r_dirty;
    logic [40:0] r_paddr;

    always #2 clk = ~clk;

    asn_tlb uut (.*);

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_lk(input logic [34:0] vpn, input logic [7:0] asn,
                          input logic [12:0] off, input logic wr, input logic usr);
        lk_valid = 1; lk_vaddr = {vpn, off}; lk_asn = asn; lk_write = wr; lk_user = usr;
    endtask

    task automatic set_fl(input logic [34:0] vpn, input logic [7:0] asn,
                          input logic [27:0] pfn, input logic [3:0] perm);
        fl_valid = 1; fl_vpn = vpn; fl_asn = asn; fl_pfn = pfn; fl_perm = perm;
    endtask

    task automatic capture();
        r_hit = lk_hit; r_miss = lk_miss; r_fault = lk_fault;
        r_paddr = lk_paddr; r_used = lk_used; r_dirty = lk_dirty;
    endtask

    task automatic finish_cycle();
        @(posedge clk);
        #1;
        lk_valid = 0; lk_write = 0; lk_user = 0;
        fl_valid = 0; inv_all = 0; inv_asn_valid = 0;
    endtask

    task automatic lookup(input logic [34:0] vpn, input logic [7:0] asn,
                          input logic [12:0] off, input logic wr, input logic usr);
        @(negedge clk);
        set_lk(vpn, asn, off, wr, usr);
        #1 capture();
        finish_cycle();
    endtask

    task automatic fill(input logic [34:0] vpn, input logic [7:0] asn,
                        input logic [27:0] pfn, input logic [3:0] perm);
        @(negedge clk);
        set_fl(vpn, asn, pfn, perm);
        finish_cycle();
    endtask

    task automatic flush_all();
        @(negedge clk);
        inv_all = 1;
        finish_cycle();
    endtask

    task automatic expect_hit(input string tag, input logic [34:0] vpn, input logic [7:0] asn,
                              input logic [27:0] pfn);
        lookup(vpn, asn, 13'h0AB, 0, 0);
        chk(tag, {63'd0, r_hit}, 64'd1);
        chk(tag, {23'd0, r_paddr}, {23'd0, pfn, 13'h0AB});
    endtask

    task automatic expect_miss(input string tag, input logic [34:0] vpn, input logic [7:0] asn);
        lookup(vpn, asn, 13'h0, 0, 0);
        chk(tag, {61'd0, r_miss, r_hit, r_fault}, {61'd0, 3'b100});
    endtask

    task automatic t_reset();
        lookup(35'h123, 8'd5, 13'h1A5, 0, 0);
        chk("R1 reset miss", {61'd0, r_miss, r_hit, r_fault}, {61'd0, 3'b100});
        chk("R7 miss paddr", {23'd0, r_paddr}, 64'd0);
    endtask

    task automatic t_round_robin();
        for (int i = 0; i < 128; i++) fill(35'(i), 8'd9, 28'(i + 'h100), 4'hF);
        expect_hit("R8 first fill present", 35'd0, 8'd9, 28'h100);
        fill(35'd128, 8'd9, 28'h180, 4'hF);
        expect_miss("R8 wrap evicts slot 0", 35'd0, 8'd9);
        expect_hit("R8 slot 1 kept", 35'd1, 8'd9, 28'h101);
        expect_hit("R8 new page", 35'd128, 8'd9, 28'h180);
    endtask

    task automatic t_overwrite();
        lookup(35'd5, 8'd9, 13'h0, 1, 0);
        fill(35'd5, 8'd9, 28'h777, 4'hF);
        lookup(35'd5, 8'd9, 13'h0, 0, 0);
        chk("R9 rewrite in place pfn", {23'd0, r_paddr}, {23'd0, 28'h777, 13'h0});
        chk("R10 fill clears use/dirty", {62'd0, r_used, r_dirty}, 64'd0);
        fill(35'd200, 8'd9, 28'h200, 4'hF);
        expect_miss("R9 pointer not advanced, slot 1 evicted", 35'd1, 8'd9);
        expect_hit("R9 slot 2 kept", 35'd2, 8'd9, 28'h102);
        flush_all();
    endtask

    task automatic t_basic();
        fill(35'h123, 8'd5, 28'hABCDE, 4'hF);
        lookup(35'h123, 8'd5, 13'h1A5, 0, 0);
        chk("R2 hit", {63'd0, r_hit}, 64'd1);
        chk("R2 paddr", {23'd0, r_paddr}, {23'd0, 28'hABCDE, 13'h1A5});
        chk("R5 use clear before first hit", {63'd0, r_used}, 64'd0);
        lookup(35'h123, 8'd5, 13'h0, 1, 0);
        chk("R5 use set by hit", {63'd0, r_used}, 64'd1);
        chk("R6 read hit leaves dirty", {63'd0, r_dirty}, 64'd0);
        lookup(35'h123, 8'd5, 13'h0, 0, 0);
        chk("R6 write hit sets dirty", {63'd0, r_dirty}, 64'd1);
    endtask

    task automatic t_asn();
        expect_miss("R3 other asn misses", 35'h123, 8'd6);
        fill(35'h123, 8'd6, 28'h55555, 4'hF);
        expect_hit("R3 asn 6 own frame", 35'h123, 8'd6, 28'h55555);
        expect_hit("R3 asn 5 own frame", 35'h123, 8'd5, 28'hABCDE);
    endtask

    task automatic t_perm();
        fill(35'h200, 8'd1, 28'h00042, 4'b0001);
        lookup(35'h200, 8'd1, 13'h10, 1, 0);
        chk("R4 kernel write fault", {62'd0, r_fault, r_hit}, 64'd2);
        chk("R4 fault paddr zero", {23'd0, r_paddr}, 64'd0);
        lookup(35'h200, 8'd1, 13'h10, 0, 1);
        chk("R4 user read fault", {62'd0, r_fault, r_hit}, 64'd2);
        lookup(35'h200, 8'd1, 13'h10, 1, 1);
        chk("R4 user write fault", {62'd0, r_fault, r_hit}, 64'd2);
        lookup(35'h200, 8'd1, 13'h10, 0, 0);
        chk("R4 kernel read hit", {62'd0, r_fault, r_hit}, 64'd1);
        chk("R5 fault leaves use clear", {63'd0, r_used}, 64'd0);
        chk("R6 fault leaves dirty clear", {63'd0, r_dirty}, 64'd0);
    endtask

    task automatic t_flushes();
        @(negedge clk);
        inv_asn_valid = 1; inv_asn = 8'd5;
        finish_cycle();
        expect_miss("R12 asn 5 flushed", 35'h123, 8'd5);
        expect_hit("R12 asn 6 kept", 35'h123, 8'd6, 28'h55555);
        flush_all();
        expect_miss("R11 asn 6 flushed", 35'h123, 8'd6);
        expect_miss("R11 asn 1 flushed", 35'h200, 8'd1);
    endtask

    task automatic t_concurrent_maint();
        @(negedge clk);
        set_fl(35'h300, 8'd3, 28'h1, 4'hF);
        inv_all = 1;
        finish_cycle();
        expect_miss("R13 fill with flush-all dropped", 35'h300, 8'd3);
        @(negedge clk);
        set_fl(35'h301, 8'd3, 28'h2, 4'hF);
        inv_asn_valid = 1; inv_asn = 8'd4;
        finish_cycle();
        expect_miss("R13 fill with flush-by-space dropped", 35'h301, 8'd3);
    endtask

    task automatic t_same_cycle();
        fill(35'h400, 8'd7, 28'h0AAAA, 4'hF);
        @(negedge clk);
        set_lk(35'h400, 8'd7, 13'h3, 1, 0);
        set_fl(35'h400, 8'd7, 28'h0BBBB, 4'hF);
        #1 capture();
        finish_cycle();
        chk("R14 lookup sees old frame", {23'd0, r_paddr}, {23'd0, 28'h0AAAA, 13'h3});
        lookup(35'h400, 8'd7, 13'h3, 0, 0);
        chk("R14 new frame after edge", {23'd0, r_paddr}, {23'd0, 28'h0BBBB, 13'h3});
        chk("R14 fill wins over use/dirty set", {62'd0, r_used, r_dirty}, 64'd0);
    endtask

    initial begin
        #8;
        @(negedge clk);
        rst_n = 1;
        t_reset();
        t_round_robin();
        t_overwrite();
        t_basic();
        t_asn();
        t_perm();
        t_flushes();
        t_concurrent_maint();
        t_same_cycle();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #600000;
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule